// File: doc/BRIEF.md
# Two-Wire Serial EEPROM Slave

This block is a synthesizable behavioural slave for a small two-wire serial EEPROM, with its byte storage held inside the block. A host writes the bus lines through a register-style strobe: each cycle with `wr_en` high presents a new clock-line and data-line level. The block compares each new level with the levels it remembers and classifies the change as a bus event: start, stop, clock rise, clock fall, or hold. The block drives the slave's data bit back on `sda_out`. That bit is an acknowledge, a stored data bit, or the last data level written when the slave is not driving.

A single cycle counter follows the transfer. It clears on start and advances on every clock rise while a transfer is open. After each acknowledge it wraps back to the start of the data phase, so there is no byte-level state machine. The link has two named states. `LS_IDLE` moves to `LS_ACTIVE` on a start event. `LS_ACTIVE` moves back to `LS_IDLE` on a stop event. A start event while in `LS_ACTIVE` is a repeated start: the state stays and the counter clears. A phase decoder maps the counter and mode to `PH_SELECT`, `PH_ACK`, `PH_ADDR` or `PH_DATA`. The action on each clock fall depends on that phase.

The `mode` port selects one of three framings. In compact mode the first byte carries a 7-bit word address and the direction flag. In the two extended modes a device-select byte comes first, followed by one or two address bytes.

Top module: `eeprom2w_slave`

## Requirements
- R1: With the clock line high, a data-line fall opens a transfer and sets the cycle count to 0. This also applies inside an open transfer (repeated start), so the next header is decoded from its first bit.
- R2: With the clock line high, a data-line rise closes the transfer.
- R3: Line levels are taken only in cycles with `wr_en` high. While a transfer is open, each clock rise advances the cycle count by one. Data bits are taken on clock falls, most significant bit first. Clock edges outside a transfer have no effect.
- R4: In compact mode (`mode`=0), cycles 1 to 8 carry a header: bits 7:1 are the word address and bit 0 is the direction (1 = read). Cycle 9 is an acknowledge, and `sda_out` is 0 while the clock is high in it.
- R5: In a compact write, data bits from cycles 10 to 17 are stored at the current word. After each byte only word-address bits 1:0 advance, so bytes wrap within an aligned group of 4 words. The slave acknowledges each byte with 0.
- R6: In a compact read, cycles 10 to 17 output the stored byte, most significant bit first. After each byte the word address advances by one, modulo 128.
- R7: In compact mode the count wraps from 18 back to 9, so every following byte uses cycles 10 to 17.
- R8: In the extended modes, cycles 1 to 8 carry a device-select byte with bit 0 as the direction (1 = read). Cycles 9, 18 and 27 are acknowledges and drive `sda_out` to 0.
- R9: In one-address-byte mode (`mode`=1), cycles 10 to 17 capture the address byte. Select bits 3:1 then become address bits 10:8. Write data uses cycles 19 to 26, and the count wraps from 27 back to 18.
- R10: In an extended write, after each byte only address bits 3:0 advance, so bytes wrap within an aligned group of 16.
- R11: In an extended read, the stored byte is output in cycles 10 to 17. The count wraps from 18 back to 9, and the full 13-bit address advances by one after each byte.
- R12: In two-address-byte mode (`mode`=2), cycles 10 to 17 and 19 to 26 capture a 13-bit address, high byte first. Data uses cycles 28 to 35, and the count wraps from 36 back to 27.
- R13: When no transfer is open, `sda_out` equals the last data level written with `wr_en` high.
- R14: Reset closes the transfer and clears the count, select and address registers. It sets the remembered line levels to 1, so `sda_out` is 1 after reset.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| mode | input | 2 | Framing: 0 compact, 1 one address byte, 2 two address bytes |
| wr_en | input | 1 | Strobe: take new line levels this cycle |
| wr_scl | input | 1 | New clock-line level |
| wr_sda | input | 1 | New data-line level from the host |
| sda_out | output | 1 | Data-line level driven by the slave |

## Verification
A wrong cycle count shows at the first acknowledge after the fault. `sda_out` then fails to read 0 one strobe after the ninth clock rise, or a read byte comes back shifted by one bit. A wrong address or page-wrap update does not show until the following read, where bytes come back from the wrong word. For that reason the bench writes runs that cross a page edge and then reads them back in order. A stuck link state shows one strobe after a stop, when `sda_out` no longer follows the written data level.

// File: rtl/eeprom2w_pkg.sv
`timescale 1ns/1ps
package eeprom2w_pkg;
    localparam int CYC_W  = 6;
    localparam int WA_W   = 13;
    localparam int DSEL_W = 4;

    typedef logic [CYC_W-1:0] cyc_t;
    typedef logic [WA_W-1:0]  wa_t;

    localparam cyc_t C_HDR_END  = 6'd8;
    localparam cyc_t C_ACK_A    = 6'd9;
    localparam cyc_t C_BYTE_END = 6'd17;
    localparam cyc_t C_ACK_B    = 6'd18;
    localparam cyc_t C_E1_WEND  = 6'd26;
    localparam cyc_t C_ACK_C    = 6'd27;
    localparam cyc_t C_E2_WEND  = 6'd35;
    localparam cyc_t C_E2_WRAP  = 6'd36;

    typedef enum logic [1:0] {
        MODE_COMPACT = 2'd0,
        MODE_EXT1    = 2'd1,
        MODE_EXT2    = 2'd2,
        MODE_EXT1B   = 2'd3
    } mode_e;

    typedef enum logic [2:0] {
        EV_NONE, EV_HOLD, EV_START, EV_STOP, EV_RISE, EV_FALL
    } bus_ev_e;

    typedef enum logic [1:0] {
        PH_SELECT, PH_ACK, PH_ADDR, PH_DATA
    } phase_e;

    typedef enum logic {
        LS_IDLE, LS_ACTIVE
    } link_e;
endpackage

// File: rtl/eeprom2w_evt.sv
`timescale 1ns/1ps
module eeprom2w_evt
    import eeprom2w_pkg::*;
(
    input  logic    wr_en,
    input  logic    scl_q,
    input  logic    sda_q,
    input  logic    scl_n,
    input  logic    sda_n,
    input  logic    active,
    output bus_ev_e ev
);
    always_comb begin
        ev = EV_NONE;
        if (wr_en) begin
            if (scl_q && scl_n) begin
                if (sda_q && !sda_n)      ev = EV_START;
                else if (!sda_q && sda_n) ev = EV_STOP;
                else                      ev = EV_HOLD;
            end else if (active && !scl_q && scl_n) begin
                ev = EV_RISE;
            end else if (active && scl_q && !scl_n) begin
                ev = EV_FALL;
            end else begin
                ev = EV_HOLD;
            end
        end
    end
endmodule

// File: rtl/eeprom2w_phase.sv
`timescale 1ns/1ps
module eeprom2w_phase
    import eeprom2w_pkg::*;
(
    input  mode_e  mode,
    input  cyc_t   cyc,
    output phase_e ph
);
    logic is_ack;
    assign is_ack = (cyc == C_ACK_A) || (cyc == C_ACK_B) || (cyc == C_ACK_C);

    always_comb begin
        ph = PH_DATA;
        unique case (mode)
            MODE_COMPACT: begin
                if (cyc <= C_HDR_END)     ph = PH_SELECT;
                else if (cyc == C_ACK_A)  ph = PH_ACK;
                else                      ph = PH_DATA;
            end
            MODE_EXT2: begin
                if (cyc <= C_HDR_END)     ph = PH_SELECT;
                else if (is_ack)          ph = PH_ACK;
                else if (cyc < C_ACK_C)   ph = PH_ADDR;
                else                      ph = PH_DATA;
            end
            MODE_EXT1, MODE_EXT1B: begin
                if (cyc <= C_HDR_END)     ph = PH_SELECT;
                else if (is_ack)          ph = PH_ACK;
                else if (cyc < C_ACK_B)   ph = PH_ADDR;
                else                      ph = PH_DATA;
            end
        endcase
    end
endmodule

// File: rtl/eeprom2w_slave.sv
`timescale 1ns/1ps
module eeprom2w_slave
    import eeprom2w_pkg::*;
#(
    parameter int MEM_AW = 11
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [1:0] mode,
    input  logic       wr_en,
    input  logic       wr_scl,
    input  logic       wr_sda,
    output logic       sda_out
);
    localparam int DEPTH = 1 << MEM_AW;

    mode_e  mode_c;
    link_e  link_q, link_d;
    cyc_t   cyc_q, cyc_d, cyc_inc;
    logic [DSEL_W-1:0] devsel_q, devsel_d;
    wa_t    addr_q, addr_d, addr_shift;
    logic   scl_q, sda_q;
    bus_ev_e ev;
    phase_e ph;

    logic [7:0]        mem [DEPTH];
    logic [MEM_AW-1:0] idx;
    logic [7:0]        cur_byte;
    logic              mem_we;
    logic [2:0]        bsel;
    logic              is_compact, is_ext2, rd_flag, in_window;

    assign mode_c     = mode_e'(mode);
    assign is_compact = (mode_c == MODE_COMPACT);
    assign is_ext2    = (mode_c == MODE_EXT2);
    assign rd_flag    = is_compact ? addr_q[0] : devsel_q[0];
    assign idx        = is_compact ? MEM_AW'(addr_q[7:1]) : addr_q[MEM_AW-1:0];
    assign cur_byte   = mem[idx];
    assign cyc_inc    = cyc_q + 6'd1;
    assign bsel       = C_BYTE_END[2:0] - cyc_q[2:0];
    assign in_window  = (cyc_q > C_ACK_A) && (cyc_q <= C_BYTE_END);

    eeprom2w_evt u_evt (
        .wr_en (wr_en),
        .scl_q (scl_q),
        .sda_q (sda_q),
        .scl_n (wr_scl),
        .sda_n (wr_sda),
        .active(link_q == LS_ACTIVE),
        .ev    (ev)
    );

    eeprom2w_phase u_phase (
        .mode(mode_c),
        .cyc (cyc_q),
        .ph  (ph)
    );

    // Address shift for the extended address phase, with select-bit merge.
    always_comb begin
        addr_shift = {addr_q[WA_W-2:0], wr_sda};
        if (!is_ext2) begin
            addr_shift = WA_W'(addr_shift[7:0]);
            if (cyc_q == C_BYTE_END)
                addr_shift = WA_W'({devsel_q[3:1], addr_shift[7:0]});
        end
    end

    // Next-state logic, driven by the decoded bus event.
    always_comb begin
        link_d   = link_q;
        cyc_d    = cyc_q;
        devsel_d = devsel_q;
        addr_d   = addr_q;
        mem_we   = 1'b0;
        unique case (ev)
            EV_START: begin
                link_d = LS_ACTIVE;
                cyc_d  = '0;
            end
            EV_STOP: begin
                link_d = LS_IDLE;
            end
            EV_RISE: begin
                cyc_d = cyc_inc;
                if (is_compact) begin
                    if (cyc_inc == C_ACK_B) begin
                        cyc_d = C_ACK_A;
                        if (addr_q[0]) addr_d = WA_W'(addr_q[7:0] + 8'd2);
                    end
                end else if (devsel_q[0] && cyc_inc == C_ACK_B) begin
                    cyc_d  = C_ACK_A;
                    addr_d = addr_q + 1'b1;
                end else if (!is_ext2 && cyc_inc == C_ACK_C) begin
                    cyc_d = C_ACK_B;
                end else if (cyc_inc == C_E2_WRAP) begin
                    cyc_d = C_ACK_C;
                end
            end
            EV_FALL: begin
                unique case (ph)
                    PH_SELECT: begin
                        if (is_compact) addr_d = WA_W'({addr_q[6:0], wr_sda});
                        else            devsel_d = {devsel_q[DSEL_W-2:0], wr_sda};
                    end
                    PH_ACK: begin
                    end
                    PH_ADDR: begin
                        if (!devsel_q[0]) addr_d = addr_shift;
                    end
                    PH_DATA: begin
                        if (is_compact) begin
                            if (!addr_q[0]) begin
                                mem_we = 1'b1;
                                if (cyc_q == C_BYTE_END) addr_d[2:1] = addr_q[2:1] + 2'd1;
                            end
                        end else if (!devsel_q[0]) begin
                            mem_we = 1'b1;
                            if ((!is_ext2 && cyc_q == C_E1_WEND) || (is_ext2 && cyc_q == C_E2_WEND))
                                addr_d[3:0] = addr_q[3:0] + 4'd1;
                        end
                    end
                endcase
            end
            EV_NONE, EV_HOLD: begin
            end
            default: begin
            end
        endcase
    end

    // State register.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            link_q   <= LS_IDLE;
            cyc_q    <= '0;
            devsel_q <= '0;
            addr_q   <= '0;
            scl_q    <= 1'b1;
            sda_q    <= 1'b1;
        end else begin
            link_q   <= link_d;
            cyc_q    <= cyc_d;
            devsel_q <= devsel_d;
            addr_q   <= addr_d;
            if (wr_en) begin
                scl_q <= wr_scl;
                sda_q <= wr_sda;
            end
        end
    end

    // Storage array: bits shift in at the current byte.
    always_ff @(posedge clk) begin
        if (mem_we) mem[idx] <= {cur_byte[6:0], wr_sda};
    end

    // Output process.
    always_comb begin
        sda_out = sda_q;
        unique case (link_q)
            LS_IDLE: sda_out = sda_q;
            LS_ACTIVE: begin
                if (ph == PH_ACK)              sda_out = 1'b0;
                else if (in_window && rd_flag) sda_out = cur_byte[bsel];
                else                           sda_out = sda_q;
            end
        endcase
    end

    // Assertions
    a_r1_start_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (ev == EV_START) |=> (link_q == LS_ACTIVE && cyc_q == '0));

    a_r2_stop_closes: assert property (@(posedge clk) disable iff (!rst_n)
        (ev == EV_STOP) |=> (link_q == LS_IDLE));

    a_r3_count_step: assert property (@(posedge clk) disable iff (!rst_n)
        (ev == EV_RISE && cyc_q < C_HDR_END) |=> (cyc_q == $past(cyc_q) + 6'd1));

    a_r4_header_ack: assert property (@(posedge clk) disable iff (!rst_n)
        (ev == EV_RISE && cyc_q == C_HDR_END) |=> !sda_out);

    a_r5_page_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (ev == EV_FALL && is_compact && !addr_q[0] && cyc_q == C_BYTE_END)
        |=> $stable(addr_q[7:3]));

    a_r7_compact_wrap: assert property (@(posedge clk) disable iff (!rst_n)
        (link_q == LS_ACTIVE && is_compact) |-> (cyc_q <= C_BYTE_END));

    a_r10_page_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (ev == EV_FALL && !is_compact && !devsel_q[0] && ph == PH_DATA)
        |=> $stable(addr_q[WA_W-1:4]));

    a_r12_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
        (link_q == LS_ACTIVE) |-> (cyc_q <= C_E2_WEND));

    a_r13_open_bus: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && link_q == LS_IDLE && ev != EV_START) |=> (sda_out == $past(wr_sda)));
endmodule

// File: tb/eeprom2w_slave_test.sv
`timescale 1ns/1ps
module eeprom2w_slave_test;
    logic       clk = 1'b0;
    logic       rst_n;
    logic [1:0] mode;
    logic       wr_en, wr_scl, wr_sda;
    logic       sda_out;

    always #2.5 clk = ~clk;

    eeprom2w_slave uut (
        .clk    (clk),
        .rst_n  (rst_n),
        .mode   (mode),
        .wr_en  (wr_en),
        .wr_scl (wr_scl),
        .wr_sda (wr_sda),
        .sda_out(sda_out)
    );

    int n_chk = 0;
    int n_bad = 0;
    logic [7:0] ref_mem [2048];
    bit         known   [2048];

    task automatic check(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic put(input logic s, input logic d);
        @(negedge clk);
        wr_en = 1'b1; wr_scl = s; wr_sda = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic bit_out(input logic b);
        put(1'b0, b); put(1'b1, b); put(1'b0, b);
    endtask

    task automatic byte_out(input logic [7:0] v);
        for (int i = 7; i >= 0; i--) bit_out(v[i]);
    endtask

    task automatic byte_in(output logic [7:0] v);
        for (int i = 7; i >= 0; i--) begin
            put(1'b0, 1'b1); put(1'b1, 1'b1);
            v[i] = sda_out;
            put(1'b0, 1'b1);
        end
    endtask

    task automatic ack_expect(input string tag);
        put(1'b0, 1'b1); put(1'b1, 1'b1);
        check(tag, int'(sda_out), 0);
        put(1'b0, 1'b1);
    endtask

    task automatic m_start;
        put(1'b0, 1'b1); put(1'b1, 1'b1); put(1'b1, 1'b0); put(1'b0, 1'b0);
    endtask

    task automatic m_stop;
        put(1'b0, 1'b0); put(1'b1, 1'b0); put(1'b1, 1'b1);
    endtask

    function automatic int c_next_wr(input int a);
        return (a & ~3) | ((a + 1) & 3);
    endfunction

    function automatic int e_next_wr(input int a);
        return (a & ~15) | ((a + 1) & 15);
    endfunction

    function automatic logic [7:0] dsel(input int a, input int md, input logic rd);
        logic [7:0] r;
        if (md == 1) r = {4'b1010, a[10:8], rd};
        else         r = {7'b1010000, rd};
        return r;
    endfunction

    task automatic c_write(input int a, input int n);
        int cur;
        logic [7:0] d;
        mode = 2'd0;
        m_start;
        byte_out({a[6:0], 1'b0});
        ack_expect("R1 R4 header ack");
        cur = a & 127;
        for (int k = 0; k < n; k++) begin
            d = 8'($urandom);
            byte_out(d);
            ack_expect("R5 R7 data ack");
            ref_mem[cur] = d; known[cur] = 1'b1;
            cur = c_next_wr(cur);
        end
        m_stop;
    endtask

    task automatic c_read(input int a, input int n, input string tag);
        int cur;
        logic [7:0] v;
        mode = 2'd0;
        m_start;
        byte_out({a[6:0], 1'b1});
        ack_expect("R4 read header ack");
        cur = a & 127;
        for (int k = 0; k < n; k++) begin
            byte_in(v);
            if (known[cur]) check(tag, int'(v), int'(ref_mem[cur]));
            cur = (cur + 1) & 127;
            bit_out(k == n - 1);
        end
        m_stop;
    endtask

    task automatic e_addr(input int a, input int md);
        m_start;
        byte_out(dsel(a, md, 1'b0));
        ack_expect("R8 select ack");
        if (md == 2) begin
            byte_out({3'b000, a[12:8]});
            ack_expect("R12 high address ack");
        end
        byte_out(a[7:0]);
        ack_expect("R8 R9 address ack");
    endtask

    task automatic e_write(input int a, input int md, input int n);
        int cur;
        logic [7:0] d;
        mode = 2'(md);
        e_addr(a, md);
        cur = a & 8191;
        for (int k = 0; k < n; k++) begin
            d = 8'($urandom);
            byte_out(d);
            ack_expect("R9 R10 data ack");
            ref_mem[cur & 2047] = d; known[cur & 2047] = 1'b1;
            cur = e_next_wr(cur);
        end
        m_stop;
    endtask

    task automatic e_read(input int a, input int md, input int n, input string tag);
        int cur;
        logic [7:0] v;
        mode = 2'(md);
        e_addr(a, md);
        m_start;
        byte_out(dsel(a, md, 1'b1));
        ack_expect("R1 R8 repeated start ack");
        cur = a & 8191;
        for (int k = 0; k < n; k++) begin
            byte_in(v);
            if (known[cur & 2047]) check(tag, int'(v), int'(ref_mem[cur & 2047]));
            cur = (cur + 1) & 8191;
            bit_out(k == n - 1);
        end
        m_stop;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: actual running expected finished");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
        $finish;
    end

    initial begin
        void'($urandom(32'd2718));
        rst_n = 1'b0; mode = 2'd0; wr_en = 1'b0; wr_scl = 1'b1; wr_sda = 1'b1;
        repeat (3) @(negedge clk);
        check("R14 reset open bus", int'(sda_out), 1);
        rst_n = 1'b1;
        @(negedge clk);

        // Strobe low: levels ignored
        wr_sda = 1'b0; wr_scl = 1'b0;
        repeat (3) @(negedge clk);
        check("R3 R13 no strobe", int'(sda_out), 1);
        wr_sda = 1'b1; wr_scl = 1'b1;

        // Compact: page rollover within 4 words
        c_write(32'h21, 6);
        c_read(32'h20, 4, "R5 R6 compact page");

        // Compact: read wraps past word 127
        c_write(127, 1);
        c_write(0, 1);
        c_read(127, 2, "R6 compact wrap");

        // Repeated start after a partial header
        mode = 2'd0;
        m_start;
        bit_out(1'b1); bit_out(1'b0); bit_out(1'b1);
        m_start;
        byte_out({7'h21, 1'b1});
        ack_expect("R1 restart header ack");
        begin
            logic [7:0] v;
            byte_in(v);
            check("R1 restart read", int'(v), int'(ref_mem[32'h21]));
            bit_out(1'b1);
        end
        m_stop;

        // Open bus after stop
        put(1'b0, 1'b0);
        check("R2 R13 open bus low", int'(sda_out), 0);
        put(1'b0, 1'b1);
        check("R2 R13 open bus high", int'(sda_out), 1);

        // Extended, one address byte: 16-byte page rollover and merged select bits
        e_write(32'h3A5, 1, 20);
        e_read(32'h3A0, 1, 16, "R9 R10 R11 ext1 page");

        // Extended, two address bytes
        e_write(32'h1234, 2, 5);
        e_read(32'h1234, 2, 5, "R12 ext2 read");

        // Random transactions
        for (int t = 0; t < 8; t++) begin
            int md, a, n;
            md = int'($urandom % 3);
            n  = 1 + int'($urandom % 6);
            if (md == 0) begin
                a = int'($urandom % 128);
                c_write(a, n);
                c_read(a, n, "R5 R6 random compact");
            end else begin
                a = int'($urandom % 2048);
                e_write(a, md, n);
                e_read(a, md, n, "R10 R11 random ext");
            end
        end

        put(1'b0, 1'b0);
        check("R13 final open bus", int'(sda_out), 0);

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
        $finish;
    end
endmodule